// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns pin activity on a set of general-purpose ports into interrupt requests. Each of its interrupt lines watches one pin. Line n always watches pin n, and a small select field per line chooses which port supplies that pin. The chosen pin passes through an asynchronous catcher. The catcher records rising and falling transitions even when a pulse is over before the next system clock edge. The recorded transitions are then carried into the clock domain by a two-flop synchronizer.

For each line, software chooses the edges that count: rising, falling, both or neither. A qualifying edge sets a sticky pending bit. A set pending bit stays set until software clears it by writing a one to that bit's position. Software can also force a pending bit through a trigger input. Each line has an unmask bit. That bit gates only the line's interrupt output, never the latching of the pending bit. The OR of all unmasked lines drives a wakeup output. The wakeup path also looks at the catchers directly, so a qualifying edge raises wakeup without any clock edge.

Changing the port select of a line does not create a transition. The line ignores transitions for a short fixed window after the change. After that window it watches the new pin from that pin's current level.

Top module: `extint_ctrl`

## Requirements
- R1: Line n is driven by pin n of the port given by that line's 3-bit select field, bits [3n+2:3n] of `port_sel_i`. Port p pin n is bit p*NLINES+n of `gpio_i`. Pins of other ports have no effect on line n.
- R2: A select value equal to or above NPORTS drives the line with a constant low. No transition on any port can then set the line.
- R3: With the line's rising enable set, a low-to-high transition on its pin sets its pending bit. The bit is visible after the third rising clock edge that follows the pin transition, and not after the second.
- R4: With only the falling enable set, only high-to-low transitions set the line. With both enables set, either transition sets it. With neither set, no transition sets it.
- R5: A high pulse that starts and ends between two clock edges still sets a line that has its rising enable set.
- R6: A pending bit stays set until a cycle in which the matching `clr_i` bit is 1. Without a new trigger in that cycle, the bit reads 0 after that clock edge.
- R7: A 1 on a `swtrig_i` bit sets that pending bit at the next clock edge, whatever the enables and the unmask bit hold.
- R8: If a detected edge or a software trigger arrives in the same cycle as a clear of that bit, the bit stays set.
- R9: `irq_o[n]` is high exactly when pending bit n and `unmask_i[n]` are both 1. A masked line still latches its pending bit.
- R10: `wakeup_o` is high while any unmasked line is pending. It also rises, before the next clock edge, when an enabled transition is caught on an unmasked line.
- R11: A change of a line's select value does not set the line, even when the old pin and the new pin differ in level. Four cycles after the change, transitions on the new pin are detected, and transitions on the old pin are not.
- R12: After a synchronous reset (`rst_n` low at a clock edge), all pending bits, `irq_o` and `wakeup_o` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gpio_i | input | NPORTS*NLINES | Pin levels; port p pin n at bit p*NLINES+n |
| port_sel_i | input | NLINES*3 | Per-line port select, line n at bits [3n+2:3n] |
| rise_en_i | input | NLINES | Per-line rising-transition enable |
| fall_en_i | input | NLINES | Per-line falling-transition enable |
| unmask_i | input | NLINES | Per-line interrupt unmask (1 = interrupt allowed) |
| clr_i | input | NLINES | Write-one-to-clear strobe for the pending bits |
| swtrig_i | input | NLINES | Write-one software trigger strobe |
| pending_o | output | NLINES | Pending bits |
| irq_o | output | NLINES | Per-line interrupt requests |
| wakeup_o | output | 1 | Combined wakeup request |

## Verification
The bench builds the block with 16 lines and only 4 ports. Select codes 4 to 7 are then out of range, so the constant-low fallback can be driven through the normal select field. Pulses are timed to start and end between clock edges, and pin transitions are placed at fixed offsets from the clock. This lets the bench check the three-edge latency of the synchronizer exactly, observe the wakeup output before any clock edge, and line up a detected edge with a clear in the same cycle. Port switches are made between pins held at different levels, so a spurious transition would show at the pending output.

// File: rtl/extint_pkg.sv
// Shared constants and types of the external interrupt controller.
// Assumes at most eight ports, so a 3-bit select covers every port.
package extint_pkg;
    localparam int SEL_W     = 3;  // width of one line's port-select field
    localparam int BLANK_CYC = 4;  // cycles a line ignores transitions after a select change
    typedef logic [SEL_W-1:0] port_sel_t;
endpackage

// File: rtl/extint_pin_mux.sv
// Per-line pin selection. It registers each line's select field and routes pin n of the
// chosen port to line n. A select at or above NPORTS yields a constant low.
// It flags a select change for one cycle so that the catcher can blank the switch.
// Assumes NPORTS <= 2**SEL_W.
module extint_pin_mux
    import extint_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int NPORTS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPORTS*NLINES-1:0]    gpio_i,
    input  logic [NLINES*SEL_W-1:0]     port_sel_i,
    output logic [NLINES-1:0]           pin_o,
    output logic [NLINES-1:0]           sel_chg_o
);

    port_sel_t sel_q [NLINES];

    for (genvar n = 0; n < NLINES; n++) begin : g_line
        port_sel_t sel_in;
        assign sel_in = port_sel_i[n*SEL_W +: SEL_W];

        // register the select so that the mux output moves only right after a clock edge
        always_ff @(posedge clk) begin
            if (!rst_n) sel_q[n] <= '0;
            else        sel_q[n] <= sel_in;
        end

        // a requested select that differs from the held one marks a switch
        assign sel_chg_o[n] = (sel_in != sel_q[n]);

        // route pin n of the selected port; an out-of-range select reads low
        always_comb begin
            pin_o[n] = 1'b0;
            for (int p = 0; p < NPORTS; p++) begin
                if (sel_q[n] == SEL_W'(p)) pin_o[n] = gpio_i[p*NLINES + n];
            end
        end
    end

endmodule

// File: rtl/extint_edge_sync.sv
// Asynchronous transition catcher plus a two-flop synchronizer for one line.
// Two flops clocked by the pin itself record a rising and a falling transition.
// Each recorded flag is synchronized and turned into a one-cycle event.
// The flag is then cleared asynchronously by a clock-domain register.
// After a select change the line is blanked for BLANK_CYC cycles: the catchers are held
// clear and events are suppressed, so a mux switch never looks like a transition.
// Assumes the pin is quiet for a few cycles between transitions of one polarity.
module extint_edge_sync
    import extint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic sel_chg_i,
    output logic rise_evt_o,
    output logic fall_evt_o,
    output logic rise_raw_o,
    output logic fall_raw_o
);

    localparam int CNT_W = $clog2(BLANK_CYC + 1);

    logic             rise_cap, fall_cap;
    logic             rise_clr_q, fall_clr_q;
    logic             rise_s1, rise_s2, rise_s2_q;
    logic             fall_s1, fall_s2, fall_s2_q;
    logic [CNT_W-1:0] blank_cnt;
    logic             blank;

    assign blank = (blank_cnt != '0);

    // catch a rising transition of the pin without any clock
    always_ff @(posedge pin_i or posedge rise_clr_q) begin
        if (rise_clr_q) rise_cap <= 1'b0;
        else            rise_cap <= 1'b1;
    end

    // catch a falling transition of the pin without any clock
    always_ff @(negedge pin_i or posedge fall_clr_q) begin
        if (fall_clr_q) fall_cap <= 1'b0;
        else            fall_cap <= 1'b1;
    end

    // blanking window counter, loaded on every select change
    always_ff @(posedge clk) begin
        if (!rst_n)         blank_cnt <= '0;
        else if (sel_chg_i) blank_cnt <= CNT_W'(BLANK_CYC);
        else if (blank)     blank_cnt <= blank_cnt - 1'b1;
    end

    // two-stage synchronizers and delayed copies for event detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_s1   <= 1'b0;
            rise_s2   <= 1'b0;
            rise_s2_q <= 1'b0;
            fall_s1   <= 1'b0;
            fall_s2   <= 1'b0;
            fall_s2_q <= 1'b0;
        end else begin
            rise_s1   <= rise_cap;
            rise_s2   <= rise_s1;
            rise_s2_q <= rise_s2;
            fall_s1   <= fall_cap;
            fall_s2   <= fall_s1;
            fall_s2_q <= fall_s2;
        end
    end

    // clear the catchers once a flag has crossed, during blanking and in reset
    always_ff @(posedge clk) begin
        rise_clr_q <= !rst_n || rise_s2 || blank || sel_chg_i;
        fall_clr_q <= !rst_n || fall_s2 || blank || sel_chg_i;
    end

    assign rise_evt_o = rise_s2 && !rise_s2_q && !blank;
    assign fall_evt_o = fall_s2 && !fall_s2_q && !blank;
    assign rise_raw_o = rise_cap && !blank;
    assign fall_raw_o = fall_cap && !blank;

    // R5
    rise_catch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_clr_q |=> !rise_s1);

    // R5
    fall_catch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_clr_q |=> !fall_s1);

    // R3
    rise_evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt_o |=> !rise_evt_o);

    // R4
    fall_evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt_o |=> !fall_evt_o);

endmodule

// File: rtl/extint_pend_reg.sv
// Sticky pending register. Detected events and software triggers set bits, and clear
// strobes reset them. A set request in the same cycle as a clear wins.
// Assumes the strobes are one clock wide per write.
module extint_pend_reg #(
    parameter int NLINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] evt_i,
    input  logic [NLINES-1:0] swtrig_i,
    input  logic [NLINES-1:0] clr_i,
    output logic [NLINES-1:0] pend_o
);

    logic [NLINES-1:0] pend_q;

    // hold, clear and set the pending bits, with set taking precedence
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | evt_i | swtrig_i;
    end

    assign pend_o = pend_q;

    // R6
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |pend_q |=> (($past(pend_q) & ~$past(clr_i) & ~pend_q) == '0));

    // R7
    swtrig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |swtrig_i |=> ((pend_q & $past(swtrig_i)) == $past(swtrig_i)));

    // R6
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(clr_i & ~evt_i & ~swtrig_i) |=> ((pend_q & $past(clr_i & ~evt_i & ~swtrig_i)) == '0));

endmodule

// File: rtl/extint_ctrl.sv
// External interrupt controller top. It selects a pin per line, catches transitions
// asynchronously, qualifies them with the per-line edge enables, and latches them as
// pending. It drives per-line interrupts and a combined wakeup, which also reacts to
// caught transitions directly.
// Assumes the control inputs are synchronous to clk.
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int NPORTS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPORTS*NLINES-1:0]    gpio_i,
    input  logic [NLINES*SEL_W-1:0]     port_sel_i,
    input  logic [NLINES-1:0]           rise_en_i,
    input  logic [NLINES-1:0]           fall_en_i,
    input  logic [NLINES-1:0]           unmask_i,
    input  logic [NLINES-1:0]           clr_i,
    input  logic [NLINES-1:0]           swtrig_i,
    output logic [NLINES-1:0]           pending_o,
    output logic [NLINES-1:0]           irq_o,
    output logic                        wakeup_o
);

    logic [NLINES-1:0] line_pin, sel_chg;
    logic [NLINES-1:0] rise_evt, fall_evt, rise_raw, fall_raw;
    logic [NLINES-1:0] line_evt, pend, wake_vec;

    extint_pin_mux #(.NLINES(NLINES), .NPORTS(NPORTS)) pin_mux_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .gpio_i     (gpio_i),
        .port_sel_i (port_sel_i),
        .pin_o      (line_pin),
        .sel_chg_o  (sel_chg)
    );

    for (genvar n = 0; n < NLINES; n++) begin : g_catch
        extint_edge_sync edge_sync_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (line_pin[n]),
            .sel_chg_i  (sel_chg[n]),
            .rise_evt_o (rise_evt[n]),
            .fall_evt_o (fall_evt[n]),
            .rise_raw_o (rise_raw[n]),
            .fall_raw_o (fall_raw[n])
        );
    end

    // qualify synchronized events with the edge enables
    assign line_evt = (rise_evt & rise_en_i) | (fall_evt & fall_en_i);

    extint_pend_reg #(.NLINES(NLINES)) pend_reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (line_evt),
        .swtrig_i (swtrig_i),
        .clr_i    (clr_i),
        .pend_o   (pend)
    );

    // per-line interrupt and clock-free wakeup terms
    always_comb begin
        irq_o    = pend & unmask_i;
        wake_vec = unmask_i & (pend | (rise_raw & rise_en_i) | (fall_raw & fall_en_i));
    end

    assign pending_o = pend;
    assign wakeup_o  = |wake_vec;

    // R10
    irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |irq_o |-> wakeup_o);

    // R9
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~pending_o) == '0);

endmodule

// File: tb/extint_ctrl_tb_top.sv
module extint_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NLINES = 16;
    localparam int NPORTS = 4;
    localparam int SELW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NPORTS*NLINES-1:0] gpio = '0;
    logic [NLINES*SELW-1:0]   port_sel = '0;
    logic [NLINES-1:0] rise_en = '0, fall_en = '0, unmask = '0, clr = '0, swtrig = '0;
    logic [NLINES-1:0] pending, irq;
    logic              wakeup;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extint_ctrl #(.NLINES(NLINES), .NPORTS(NPORTS)) dut_i (
        .clk(clk), .rst_n(rst_n), .gpio_i(gpio), .port_sel_i(port_sel),
        .rise_en_i(rise_en), .fall_en_i(fall_en), .unmask_i(unmask),
        .clr_i(clr), .swtrig_i(swtrig), .pending_o(pending), .irq_o(irq),
        .wakeup_o(wakeup)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_pin(input int p, input int n, input logic v);
        gpio[p*NLINES + n] = v;
    endtask

    task automatic set_sel(input int n, input int v);
        port_sel[n*SELW +: SELW] = SELW'(v);
    endtask

    task automatic clear_all();
        clr = '1;
        wait_clk(1);
        clr = '0;
    endtask

    task automatic restore();
        rise_en = '0; fall_en = '0; unmask = '0; gpio = '0; port_sel = '0;
        wait_clk(8);
        clear_all();
    endtask

    task automatic t_reset();
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);
        chk("R12 pending", 32'(pending), 32'h0);
        chk("R12 irq", 32'(irq), 32'h0);
        chk("R12 wakeup", 32'(wakeup), 32'h0);
    endtask

    task automatic t_rise_select();
        set_sel(3, 2); rise_en[3] = 1'b1;
        wait_clk(8); clear_all();
        set_pin(2, 3, 1'b1);
        wait_clk(2);
        chk("R3 not yet after 2 edges", 32'(pending), 32'h0);
        wait_clk(1);
        chk("R3 set after 3 edges", 32'(pending), 32'h0008);
        clear_all();
        set_pin(1, 3, 1'b1);
        wait_clk(5);
        chk("R1 other port ignored", 32'(pending), 32'h0);
        set_pin(2, 3, 1'b0);
        wait_clk(5);
        chk("R3 falling ignored", 32'(pending), 32'h0);
        restore();
    endtask

    task automatic t_fall_both();
        set_sel(5, 1); fall_en[5] = 1'b1;
        set_sel(7, 3); rise_en[7] = 1'b1; fall_en[7] = 1'b1;
        set_sel(8, 0);
        wait_clk(8); clear_all();
        set_pin(1, 5, 1'b1); set_pin(0, 8, 1'b1);
        wait_clk(5);
        chk("R4 fall-only ignores rise", 32'(pending), 32'h0);
        set_pin(1, 5, 1'b0); set_pin(0, 8, 1'b0);
        wait_clk(5);
        chk("R4 fall-only sets, none stays clear", 32'(pending), 32'h0020);
        clear_all();
        set_pin(3, 7, 1'b1);
        wait_clk(5);
        chk("R4 both on rise", 32'(pending), 32'h0080);
        clear_all();
        set_pin(3, 7, 1'b0);
        wait_clk(5);
        chk("R4 both on fall", 32'(pending), 32'h0080);
        restore();
    endtask

    task automatic t_short_pulse();
        set_sel(9, 1); rise_en[9] = 1'b1;
        wait_clk(8); clear_all();
        set_pin(1, 9, 1'b1);
        #2;
        set_pin(1, 9, 1'b0);
        wait_clk(5);
        chk("R5 short pulse caught", 32'(pending), 32'h0200);
        restore();
    endtask

    task automatic t_mask();
        set_sel(3, 0); rise_en[3] = 1'b1;
        wait_clk(8); clear_all();
        set_pin(0, 3, 1'b1);
        wait_clk(5);
        chk("R9 masked still pending", 32'(pending), 32'h0008);
        chk("R9 masked no irq", 32'(irq), 32'h0);
        chk("R10 masked no wakeup", 32'(wakeup), 32'h0);
        unmask[3] = 1'b1;
        #1;
        chk("R9 unmasked irq", 32'(irq), 32'h0008);
        chk("R10 wakeup from pending", 32'(wakeup), 32'h1);
        wait_clk(6);
        chk("R6 sticky without clear", 32'(pending), 32'h0008);
        restore();
    endtask

    task automatic t_swtrig_collide();
        clear_all();
        swtrig[12] = 1'b1;
        wait_clk(1);
        swtrig = '0;
        chk("R7 swtrig with no enable", 32'(pending), 32'h1000);
        swtrig[12] = 1'b1; clr[12] = 1'b1;
        wait_clk(1);
        swtrig = '0; clr = '0;
        chk("R8 swtrig beats clear", 32'(pending), 32'h1000);
        clr[12] = 1'b1;
        wait_clk(1);
        clr = '0;
        chk("R6 clear drops bit", 32'(pending), 32'h0);
        set_sel(6, 0); rise_en[6] = 1'b1;
        wait_clk(8);
        swtrig[6] = 1'b1;
        wait_clk(1);
        swtrig = '0;
        set_pin(0, 6, 1'b1);
        wait_clk(2);
        clr[6] = 1'b1;
        wait_clk(1);
        clr = '0;
        chk("R8 edge beats clear", 32'(pending), 32'h0040);
        restore();
    endtask

    task automatic t_port_switch();
        set_sel(4, 0); rise_en[4] = 1'b1; fall_en[4] = 1'b1;
        set_pin(3, 4, 1'b1);
        wait_clk(8); clear_all();
        set_sel(4, 3);
        wait_clk(8);
        chk("R11 switch makes no edge", 32'(pending), 32'h0);
        set_pin(0, 4, 1'b1);
        wait_clk(5);
        chk("R11 old pin ignored", 32'(pending), 32'h0);
        set_pin(3, 4, 1'b0);
        wait_clk(5);
        chk("R11 new pin detected", 32'(pending), 32'h0010);
        restore();
    endtask

    task automatic t_out_of_range();
        set_sel(10, 6); rise_en[10] = 1'b1; fall_en[10] = 1'b1;
        wait_clk(8); clear_all();
        for (int p = 0; p < NPORTS; p++) set_pin(p, 10, 1'b1);
        wait_clk(5);
        for (int p = 0; p < NPORTS; p++) set_pin(p, 10, 1'b0);
        wait_clk(5);
        chk("R2 out-of-range select stays low", 32'(pending), 32'h0);
        restore();
    endtask

    task automatic t_wake_async();
        set_sel(11, 2); rise_en[11] = 1'b1; unmask[11] = 1'b1;
        wait_clk(8); clear_all();
        chk("R10 wakeup idle", 32'(wakeup), 32'h0);
        set_pin(2, 11, 1'b1);
        #2;
        chk("R10 wakeup before clock", 32'(wakeup), 32'h1);
        chk("R3 pending not yet", 32'(pending), 32'h0);
        wait_clk(3);
        chk("R9 irq after latch", 32'(irq), 32'h0800);
        unmask[11] = 1'b0;
        #1;
        chk("R10 wakeup drops when masked", 32'(wakeup), 32'h0);
        restore();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_rise_select();
        t_fall_both();
        t_short_pulse();
        t_mask();
        t_swtrig_collide();
        t_port_switch();
        t_out_of_range();
        t_wake_async();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule